// File: doc/BRIEF.md
# USB Endpoint Receive FIFO

This block buffers the bytes of one USB OUT endpoint between the endpoint controller, which pushes each received byte, and the software read port, which pops bytes one at a time. A packet may be longer than the buffer. Software therefore drains bytes while the rest of the packet is still arriving. The block reports how many bytes are waiting, and how many more bytes can be accepted before the next write overruns.

Free space is compared every cycle against a threshold that software programs. When it is at or below that threshold, a sticky warning flag is raised so that software can start draining. A write into a full buffer is dropped and sets a sticky overrun flag. A read from an empty buffer repeats the byte returned last and does not move the read position. A flush empties the buffer in one cycle. Each position carries an extra wrap bit, so a full buffer and an empty buffer are told apart even when their address bits are equal. The depth need not be a power of two.

Top module: `ep_rx_fifo`

## Requirements
- R1: Accepted bytes are returned in the order they were written. This holds across any number of wraps of either position past the last slot (DEPTH-1) back to slot 0.
- R2: A read with at least one byte stored presents that byte on `rd_data` in the cycle after `rd_en` is sampled, and consumes it.
- R3: A read with no byte stored (underrun) leaves `rd_data` holding the byte returned last and leaves `count` unchanged.
- R4: A write while `count` equals DEPTH is dropped and does not alter the stored bytes. `overrun` is set the cycle after and stays set until `flag_clr` or `flush`.
- R5: `count` equals accepted writes minus accepted reads since the last reset or flush. It ranges from 0 to DEPTH and changes in the cycle after the access.
- R6: `free_level` equals DEPTH minus `count` at all times.
- R7: `warn` is set in the cycle after any cycle in which `free_level` is less than or equal to `warn_level`. It is cleared by `flag_clr` only when that condition is false in the same cycle, because setting has priority over clearing.
- R8: `flush` makes `count` zero and clears `overrun` in the next cycle. A read or write in the same cycle is ignored, and `rd_data` keeps its value.
- R9: A read and a write in the same cycle, with 0 < `count` < DEPTH, are both performed and leave `count` unchanged.
- R10: After reset `count` is 0, `free_level` is DEPTH, `warn` and `overrun` are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Endpoint controller pushes one byte |
| wr_data | input | DW | Byte to push |
| rd_en | input | 1 | Software pops one byte |
| rd_data | output | DW | Byte popped last (registered) |
| flush | input | 1 | Empty the buffer and clear overrun |
| warn_level | input | $clog2(DEPTH)+1 | Free-space warning threshold |
| flag_clr | input | 1 | Clear pulse for the sticky flags |
| count | output | $clog2(DEPTH)+1 | Bytes available to read |
| free_level | output | $clog2(DEPTH)+1 | Bytes that can still be written |
| warn | output | 1 | Sticky low-free-space warning |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The main function is driven with four patterns. Short bursts written and then drained separate ordering errors from counting errors. A fill that crosses the wrap point shows whether the wrap bit and the slot addressing stay consistent. Same-cycle reads and writes at a steady level show whether the net change is applied. A packet longer than the buffer, drained with periodic stalls, drives the buffer to full and into overrun. A behavioural queue model, compared every cycle, tells a dropped byte apart from a repeated one. Directed cases cover underrun repetition, flag priority and flush.

// File: rtl/ep_rx_fifo_pkg.sv
package ep_rx_fifo_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_FLUSH = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_BOTH  = 3'd4
    } fifo_op_e;

    function automatic fifo_op_e decode_op(input logic fl, input logic rd_ok, input logic wr_ok);
        if (fl)                 return OP_FLUSH;
        else if (rd_ok && wr_ok) return OP_BOTH;
        else if (rd_ok)          return OP_READ;
        else if (wr_ok)          return OP_WRITE;
        else                     return OP_HOLD;
    endfunction
endpackage

// File: rtl/ep_rx_fifo_ptr.sv
module ep_rx_fifo_ptr #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          zero_i,
    output logic [AW-1:0] addr_o,
    output logic          wrap_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          wrap;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (zero_i) begin
            ptr_d = '0;
        end else if (step_i) begin
            if (ptr_q.addr == LAST) begin
                ptr_d.addr = '0;
                ptr_d.wrap = ~ptr_q.wrap;
            end else begin
                ptr_d.addr = ptr_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign addr_o = ptr_q.addr;
    assign wrap_o = ptr_q.wrap;
endmodule

// File: rtl/ep_rx_fifo_mem.sv
module ep_rx_fifo_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } out_t;

    logic [DW-1:0] store_q [DEPTH];
    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (re_i) out_d.rdata = store_q[raddr_i];
    end

    always_ff @(posedge clk) begin
        if (we_i) store_q[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rdata_o = out_q.rdata;
endmodule

// File: rtl/ep_rx_fifo_stat.sv
module ep_rx_fifo_stat #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] waddr_i,
    input  logic          wwrap_i,
    input  logic [AW-1:0] raddr_i,
    input  logic          rwrap_i,
    input  logic [CW-1:0] warn_level_i,
    input  logic          wr_req_i,
    input  logic          flush_i,
    input  logic          clr_i,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] free_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          warn_o,
    output logic          overrun_o
);
    localparam logic [CW-1:0] SIZE = CW'(DEPTH);

    typedef struct packed {
        logic warn;
        logic overrun;
    } flags_t;

    flags_t flg_d, flg_q;
    logic [CW-1:0] span;

    always_comb begin
        if (wwrap_i == rwrap_i) span = CW'(waddr_i) - CW'(raddr_i);
        else                    span = SIZE - CW'(raddr_i) + CW'(waddr_i);
    end

    assign count_o = span;
    assign free_o  = SIZE - span;
    assign empty_o = (span == '0);
    assign full_o  = (span == SIZE);

    always_comb begin
        flg_d = flg_q;
        if (clr_i) begin
            flg_d.warn    = 1'b0;
            flg_d.overrun = 1'b0;
        end
        if (free_o <= warn_level_i) flg_d.warn = 1'b1;
        if (flush_i)                flg_d.overrun = 1'b0;
        else if (wr_req_i && full_o) flg_d.overrun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign warn_o    = flg_q.warn;
    assign overrun_o = flg_q.overrun;
endmodule

// File: rtl/ep_rx_fifo.sv
module ep_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          flush,
    input  logic [CW-1:0] warn_level,
    input  logic          flag_clr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] free_level,
    output logic          warn,
    output logic          overrun
);
    import ep_rx_fifo_pkg::*;

    fifo_op_e      op;
    logic          empty_s, full_s;
    logic          do_rd, do_wr;
    logic [AW-1:0] waddr, raddr;
    logic          wwrap, rwrap;

    assign op    = decode_op(flush, rd_en && !empty_s, wr_en && !full_s);
    assign do_rd = (op == OP_READ)  || (op == OP_BOTH);
    assign do_wr = (op == OP_WRITE) || (op == OP_BOTH);

    ep_rx_fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .step_i(do_wr), .zero_i(op == OP_FLUSH),
        .addr_o(waddr), .wrap_o(wwrap)
    );

    ep_rx_fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk(clk), .rst_n(rst_n), .step_i(do_rd), .zero_i(op == OP_FLUSH),
        .addr_o(raddr), .wrap_o(rwrap)
    );

    ep_rx_fifo_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we_i(do_wr), .waddr_i(waddr), .wdata_i(wr_data),
        .re_i(do_rd), .raddr_i(raddr), .rdata_o(rd_data)
    );

    ep_rx_fifo_stat #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .waddr_i(waddr), .wwrap_i(wwrap), .raddr_i(raddr), .rwrap_i(rwrap),
        .warn_level_i(warn_level), .wr_req_i(wr_en), .flush_i(flush),
        .clr_i(flag_clr),
        .count_o(count), .free_o(free_level),
        .empty_o(empty_s), .full_o(full_s),
        .warn_o(warn), .overrun_o(overrun)
    );
endmodule

// File: rtl/ep_rx_fifo_chk.sv
module ep_rx_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          flush,
    input logic [CW-1:0] warn_level,
    input logic          flag_clr,
    input logic [CW-1:0] count,
    input logic [CW-1:0] free_level,
    input logic          warn,
    input logic          overrun
);
    localparam logic [CW-1:0] SIZE = CW'(DEPTH);

    assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= SIZE);

    assert_underrun_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rd_en && !wr_en && !flush) |=> (count == '0 && $stable(rd_data)));

    assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == SIZE && wr_en && !flush) |=> overrun);

    assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flag_clr && !flush) |=> overrun);

    assert_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !flush && count < SIZE) |=> (count == $past(count) + 1'b1));

    assert_warn_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (free_level <= warn_level) |=> warn);

    assert_warn_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warn && !flag_clr) |=> warn);

    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !overrun && $stable(rd_data)));

    assert_both_net_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !flush && count != '0 && count != SIZE) |=> $stable(count));
endmodule

bind ep_rx_fifo ep_rx_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .flush(flush), .warn_level(warn_level), .flag_clr(flag_clr), .count(count),
    .free_level(free_level), .warn(warn), .overrun(overrun)
);

// File: tb/ep_rx_fifo_test.sv
module ep_rx_fifo_test;
    localparam int DEPTH = 64;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0, flag_clr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] warn_level = '0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] count, free_level;
    logic          warn, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ep_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .flush(flush),
        .warn_level(warn_level), .flag_clr(flag_clr), .count(count),
        .free_level(free_level), .warn(warn), .overrun(overrun)
    );

    // behavioural reference
    logic [DW-1:0] mq[$];
    logic [DW-1:0] m_rd = '0;
    bit            m_warn = 1'b0, m_ovr = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_rd   <= '0;
            m_warn <= 1'b0;
            m_ovr  <= 1'b0;
        end else begin
            int  sz;
            bit  was_full, was_empty;
            sz        = mq.size();
            was_full  = (sz == DEPTH);
            was_empty = (sz == 0);
            m_warn <= (m_warn && !flag_clr) || ((DEPTH - sz) <= int'(warn_level));
            if (flush) begin
                mq.delete();
                m_ovr <= 1'b0;
            end else begin
                m_ovr <= (m_ovr && !flag_clr) || (wr_en && was_full);
                if (rd_en && !was_empty) m_rd <= mq.pop_front();
                if (wr_en && !was_full)  mq.push_back(wr_data);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rd_data == m_rd, "R2", "rd_data", int'(rd_data), int'(m_rd));
            check(int'(count) == mq.size(), "R5", "count", int'(count), mq.size());
            check(int'(free_level) == DEPTH - mq.size(), "R6", "free_level",
                  int'(free_level), DEPTH - mq.size());
            check(warn == m_warn, "R7", "warn", int'(warn), int'(m_warn));
            check(overrun == m_ovr, "R4", "overrun", int'(overrun), int'(m_ovr));
        end
    end

    task automatic step(input bit w, input logic [DW-1:0] d, input bit r,
                        input bit f = 1'b0, input bit c = 1'b0);
        wr_en = w; wr_data = d; rd_en = r; flush = f; flag_clr = c;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // r10_ reset state
        check(count == '0, "R10", "count after reset", int'(count), 0);
        check(int'(free_level) == DEPTH, "R10", "free after reset", int'(free_level), DEPTH);
        check(!warn && !overrun, "R10", "flags after reset", int'({warn, overrun}), 0);
        check(rd_data == '0, "R10", "rd_data after reset", int'(rd_data), 0);

        // short burst then drain; then underrun R3
        for (int i = 0; i < 10; i++) step(1'b1, DW'(8'h10 + i), 1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1);
        check(rd_data == 8'h19, "R2", "last drained byte", int'(rd_data), 'h19);
        held = rd_data;
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        check(rd_data == held, "R3", "underrun repeats byte", int'(rd_data), int'(held));
        check(count == '0, "R3", "underrun count", int'(count), 0);

        // fill across the wrap point, then overrun R4
        for (int i = 0; i < DEPTH; i++) step(1'b1, DW'(8'h40 + i), 1'b0);
        check(int'(count) == DEPTH, "R5", "count when full", int'(count), DEPTH);
        step(1'b1, 8'hEE, 1'b0);
        check(overrun == 1'b1, "R4", "overrun on full write", int'(overrun), 1);
        check(int'(count) == DEPTH, "R4", "dropped write count", int'(count), DEPTH);

        // warning priority R7 (full, free 0 <= 8)
        warn_level = CW'(8);
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0, 1'b1);
        check(warn == 1'b1, "R7", "set beats clear", int'(warn), 1);
        check(overrun == 1'b0, "R4", "flag_clr clears overrun", int'(overrun), 0);

        // drain 60; first byte written across wrap must come back in order R1
        step(1'b0, '0, 1'b1);
        check(rd_data == 8'h40, "R1", "first byte after wrap", int'(rd_data), 'h40);
        for (int i = 1; i < 60; i++) step(1'b0, '0, 1'b1);
        check(rd_data == DW'(8'h40 + 59), "R1", "ordered across wrap",
              int'(rd_data), 'h40 + 59);
        step(1'b0, '0, 1'b0, 1'b0, 1'b1);
        check(warn == 1'b0, "R7", "clear when free above level", int'(warn), 0);

        // simultaneous read and write at level 4 R9
        for (int i = 0; i < 20; i++) step(1'b1, DW'(8'h80 + i), 1'b1);
        check(int'(count) == 4, "R9", "count steady under rd+wr", int'(count), 4);

        // packet longer than the buffer, drained with stalls
        for (int i = 0; i < 300; i++) step(1'b1, DW'(i), (i % 4) != 0);
        check(m_ovr == overrun, "R4", "overrun after long packet", int'(overrun), int'(m_ovr));

        // flush with concurrent access R8
        held = rd_data;
        step(1'b1, 8'h55, 1'b1, 1'b1);
        check(count == '0, "R8", "count after flush", int'(count), 0);
        check(overrun == 1'b0, "R8", "overrun after flush", int'(overrun), 0);
        check(rd_data == held, "R8", "rd_data kept on flush", int'(rd_data), int'(held));
        step(1'b1, 8'hA5, 1'b0);
        step(1'b0, '0, 1'b1);
        check(rd_data == 8'hA5, "R1", "first byte after flush", int'(rd_data), 'hA5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule